// File: doc/BRIEF.md
# Block-Lock Write Protection Controller

This block owns the one-byte protection control register of a serial nonvolatile memory and rules on every page commit that the command sequencer asks for. The sequencer forwards data bytes aimed at the reserved register address, register reads and commit requests. Each commit carries either the target page address or a flag that marks it as a register commit. One cycle after each commit request the block answers with a done pulse and an allow or deny bit. It also drives the clear of the write-enable latch.

Protection has two layers. The first is a two-bit block-protect code that fences off none, the upper quarter, the upper half or all of the array. The quarter boundaries come from the array-depth parameter. The second is a hardware lock. It is active when the external write-protect pin is low and the enable bit of the register is set. While it is active the register refuses all writes, including a write to the enable bit itself, so the protection can lock itself. A register byte is held in a staging buffer and takes effect only at the end of an internal write window that the commit starts.

The controller state machine has four states. IDLE means nothing is staged. STAGED holds exactly one byte. OVERRUN means a second byte arrived, so the operation is spoiled. BURN is the internal write window of BURN_CYCLES cycles. The transitions are: IDLE to STAGED on a byte load. STAGED to OVERRUN on a second load. STAGED to BURN on an allowed register commit. STAGED to IDLE on a denied commit, a new sequence or an active hardware lock (cancel). OVERRUN to IDLE on a commit, a new sequence or an active hardware lock. BURN to IDLE when the window counter expires, at which point the register is updated.

Top module: `blocklock_guard`

## Requirements
- R1: After reset the register is 0x00, no commit response is pending, and the first register read returns 0x00 with the read-valid bit set.
- R2: Register bit 7 is the lock-enable bit and bits 3:2 are the block-protect code. Every other bit is stored as 0 and reads as 0.
- R3: An array commit is decided on its page base, which is the address with the low log2(PAGE) bits cleared. With DEPTH=2048, code 00 protects nothing, 01 protects bases of 0x600 and up, 10 protects bases of 0x400 and up, and 11 protects every address. A protected page is denied.
- R4: The register is outside every block-protect range. A register commit is not refused because of the block-protect code.
- R5: The hardware lock is active only when the pin is low (0) and bit 7 is 1. While it is active a register commit is denied. With the pin high, or with bit 7 clear, the pin has no effect on register commits.
- R6: Array commits depend only on the block-protect code and the address, whatever the state of the pin and bit 7.
- R7: A second byte load before the commit spoils the operation. The following register commit is denied and the register keeps its value.
- R8: A register commit with no staged byte is denied.
- R9: A register value committed at clock edge E becomes visible at edge E+BURN_CYCLES. Reads in between return the old value.
- R10: After a sequence start, only the first register read is valid and returns the register. Later reads return 0x00 with read-valid low until the next sequence start.
- R11: The latch-clear output is high whenever the pin is low, and for the one cycle in which a deny is reported.
- R12: An active hardware lock cancels a staged register byte, so a later commit is denied. Once BURN has begun, the pin has no effect and the update still lands.
- R13: Every commit that arrives during BURN is denied.
- R14: The done and allow outputs are registered. They appear one clock after the edge that samples the commit request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wprot_n | input | 1 | Write-protect pin level, low = protect |
| seq_begin | input | 1 | Start of a new command sequence |
| reg_wr_vld | input | 1 | A data byte aimed at the register is delivered |
| reg_wr_data | input | 8 | Byte aimed at the register |
| reg_rd_req | input | 1 | Register read request |
| rd_data | output | 8 | Register read data |
| rd_ok | output | 1 | Read data is valid |
| commit_req | input | 1 | Commit request |
| commit_is_reg | input | 1 | Commit targets the register |
| commit_addr | input | ADDR_W | Target address of an array commit |
| commit_done | output | 1 | Commit decision is reported |
| commit_ok | output | 1 | Commit is allowed |
| wel_clr | output | 1 | Clear for the write-enable latch |

## Verification
A corrupted register shows up as wrong read data on the first read after a sequence start. It shows up sooner as wrong allow bits on the next array commit, one cycle after the request. A state machine stuck in BURN denies every commit that follows, and one that never enters BURN leaves the register unchanged when it is read back BURN_CYCLES cycles later. A lost cancel or a lost overrun appears as an allow on the very next register commit, where a deny was expected.

// File: rtl/blocklock_pkg.sv
package blocklock_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STAGED  = 2'd1,
        ST_OVERRUN = 2'd2,
        ST_BURN    = 2'd3
    } bl_state_e;

    localparam int LOCK_BIT = 7;
    localparam int BP_HI    = 3;
    localparam int BP_LO    = 2;
    localparam logic [7:0] KEEP_MASK = 8'h8C;

    function automatic logic [7:0] clean_byte(input logic [7:0] b);
        return b & KEEP_MASK;
    endfunction
endpackage

// File: rtl/bl_range_check.sv
module bl_range_check #(
    parameter int DEPTH  = 2048,
    parameter int PAGE   = 32,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic [1:0]        bp_code,
    input  logic [ADDR_W-1:0] addr,
    output logic              in_prot
);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ~ADDR_W'(PAGE - 1);
    localparam logic [ADDR_W-1:0] UPPER_Q   = ADDR_W'(DEPTH - DEPTH / 4);
    localparam logic [ADDR_W-1:0] UPPER_H   = ADDR_W'(DEPTH / 2);

    logic [ADDR_W-1:0] page_base;

    always_comb begin
        page_base = addr & PAGE_MASK;
        unique case (bp_code)
            2'b00:   in_prot = 1'b0;
            2'b01:   in_prot = (page_base >= UPPER_Q);
            2'b10:   in_prot = (page_base >= UPPER_H);
            default: in_prot = 1'b1;
        endcase
    end
endmodule

// File: rtl/bl_ctrl_fsm.sv
module bl_ctrl_fsm
    import blocklock_pkg::*;
#(
    parameter int BURN_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seq_begin,
    input  logic       reg_wr_vld,
    input  logic [7:0] reg_wr_data,
    input  logic       reg_commit,
    input  logic       hw_lock,
    output logic [7:0] ctrl_q,
    output logic       reg_allow,
    output logic       in_burn
);
    localparam int CNT_W = $clog2(BURN_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BURN_CYCLES - 1);

    bl_state_e         state_q, state_d;
    logic [7:0]        stage_q, stage_d;
    logic [7:0]        ctrl_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            stage_q <= 8'h00;
            ctrl_q  <= 8'h00;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            stage_q <= stage_d;
            ctrl_q  <= ctrl_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        stage_d   = stage_q;
        ctrl_d    = ctrl_q;
        cnt_d     = cnt_q;
        reg_allow = 1'b0;
        in_burn   = (state_q == ST_BURN);
        unique case (state_q)
            ST_IDLE: begin
                if (reg_commit) begin
                    state_d = ST_IDLE;
                end else if (reg_wr_vld) begin
                    state_d = ST_STAGED;
                    stage_d = clean_byte(reg_wr_data);
                end
            end
            ST_STAGED: begin
                if (reg_commit) begin
                    if (!hw_lock) begin
                        reg_allow = 1'b1;
                        state_d   = ST_BURN;
                        cnt_d     = CNT_LOAD;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else if (hw_lock) begin
                    state_d = ST_IDLE;
                end else if (reg_wr_vld) begin
                    state_d = ST_OVERRUN;
                end else if (seq_begin) begin
                    state_d = ST_IDLE;
                end
            end
            ST_OVERRUN: begin
                if (reg_commit || seq_begin || hw_lock) begin
                    state_d = ST_IDLE;
                end
            end
            ST_BURN: begin
                if (cnt_q == '0) begin
                    ctrl_d  = stage_q;
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/bl_read_port.sv
module bl_read_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seq_begin,
    input  logic       reg_rd_req,
    input  logic [7:0] ctrl_q,
    output logic [7:0] rd_data,
    output logic       rd_ok
);
    logic first_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b1;
            rd_data <= 8'h00;
            rd_ok   <= 1'b0;
        end else begin
            if (reg_rd_req && first_q) begin
                rd_data <= ctrl_q;
                rd_ok   <= 1'b1;
            end else begin
                rd_data <= 8'h00;
                rd_ok   <= 1'b0;
            end
            if (seq_begin)       first_q <= 1'b1;
            else if (reg_rd_req) first_q <= 1'b0;
        end
    end
endmodule

// File: rtl/blocklock_guard.sv
module blocklock_guard
    import blocklock_pkg::*;
#(
    parameter int DEPTH       = 2048,
    parameter int PAGE        = 32,
    parameter int BURN_CYCLES = 8,
    parameter int ADDR_W      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wprot_n,
    input  logic              seq_begin,
    input  logic              reg_wr_vld,
    input  logic [7:0]        reg_wr_data,
    input  logic              reg_rd_req,
    output logic [7:0]        rd_data,
    output logic              rd_ok,
    input  logic              commit_req,
    input  logic              commit_is_reg,
    input  logic [ADDR_W-1:0] commit_addr,
    output logic              commit_done,
    output logic              commit_ok,
    output logic              wel_clr
);
    logic [7:0] ctrl_q;
    logic       hw_lock;
    logic       reg_allow;
    logic       in_burn;
    logic       in_prot;
    logic       decide;

    assign hw_lock = !wprot_n && ctrl_q[LOCK_BIT];

    bl_ctrl_fsm #(.BURN_CYCLES(BURN_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .seq_begin  (seq_begin),
        .reg_wr_vld (reg_wr_vld),
        .reg_wr_data(reg_wr_data),
        .reg_commit (commit_req && commit_is_reg),
        .hw_lock    (hw_lock),
        .ctrl_q     (ctrl_q),
        .reg_allow  (reg_allow),
        .in_burn    (in_burn)
    );

    bl_range_check #(.DEPTH(DEPTH), .PAGE(PAGE), .ADDR_W(ADDR_W)) u_range (
        .bp_code(ctrl_q[BP_HI:BP_LO]),
        .addr   (commit_addr),
        .in_prot(in_prot)
    );

    bl_read_port u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .seq_begin (seq_begin),
        .reg_rd_req(reg_rd_req),
        .ctrl_q    (ctrl_q),
        .rd_data   (rd_data),
        .rd_ok     (rd_ok)
    );

    always_comb begin
        if (in_burn)            decide = 1'b0;
        else if (commit_is_reg) decide = reg_allow;
        else                    decide = !in_prot;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_done <= 1'b0;
            commit_ok   <= 1'b0;
        end else begin
            commit_done <= commit_req;
            commit_ok   <= commit_req && decide;
        end
    end

    assign wel_clr = !wprot_n || (commit_done && !commit_ok);
endmodule

// File: rtl/blocklock_guard_chk.sv
module blocklock_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wprot_n,
    input logic       commit_req,
    input logic       commit_is_reg,
    input logic       commit_done,
    input logic       commit_ok,
    input logic       reg_rd_req,
    input logic       rd_ok,
    input logic [7:0] rd_data,
    input logic       wel_clr,
    input logic [7:0] ctrl_q,
    input logic       in_burn
);
    // R14
    ok_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_ok |-> commit_done);
    // R14
    done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |=> commit_done);
    // R11
    pin_low_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wprot_n |-> wel_clr);
    // R2
    reserved_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & 8'h73) == 8'h00);
    // R10
    rd_ok_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_req |=> !rd_ok);
    // R3
    full_lock_denies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && !commit_is_reg && ctrl_q[3:2] == 2'b11) |=> !commit_ok);
    // R13
    burn_denies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && in_burn) |=> !commit_ok);
    // R5
    lock_holds_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wprot_n && ctrl_q[7] && !in_burn) |=> $stable(ctrl_q));
endmodule

bind blocklock_guard blocklock_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wprot_n      (wprot_n),
    .commit_req   (commit_req),
    .commit_is_reg(commit_is_reg),
    .commit_done  (commit_done),
    .commit_ok    (commit_ok),
    .reg_rd_req   (reg_rd_req),
    .rd_ok        (rd_ok),
    .rd_data      (rd_data),
    .wel_clr      (wel_clr),
    .ctrl_q       (ctrl_q),
    .in_burn      (in_burn)
);

// File: tb/tb_blocklock_guard.sv
module tb_blocklock_guard;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 2048;
    localparam int PAGE  = 32;
    localparam int BURN  = 8;
    localparam int AW    = 11;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          wprot_n = 1;
    logic          seq_begin = 0;
    logic          reg_wr_vld = 0;
    logic [7:0]    reg_wr_data = 0;
    logic          reg_rd_req = 0;
    logic [7:0]    rd_data;
    logic          rd_ok;
    logic          commit_req = 0;
    logic          commit_is_reg = 0;
    logic [AW-1:0] commit_addr = 0;
    logic          commit_done;
    logic          commit_ok;
    logic          wel_clr;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] mdl = 8'h00;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blocklock_guard #(.DEPTH(DEPTH), .PAGE(PAGE), .BURN_CYCLES(BURN)) dut (
        .clk(clk), .rst_n(rst_n), .wprot_n(wprot_n), .seq_begin(seq_begin),
        .reg_wr_vld(reg_wr_vld), .reg_wr_data(reg_wr_data), .reg_rd_req(reg_rd_req),
        .rd_data(rd_data), .rd_ok(rd_ok), .commit_req(commit_req),
        .commit_is_reg(commit_is_reg), .commit_addr(commit_addr),
        .commit_done(commit_done), .commit_ok(commit_ok), .wel_clr(wel_clr)
    );

    function automatic bit exp_array_ok(input logic [7:0] c, input logic [AW-1:0] a);
        int base;
        base = int'(a) & ~(PAGE - 1);
        case (c[3:2])
            2'b00:   return 1'b1;
            2'b01:   return base < (DEPTH * 3 / 4);
            2'b10:   return base < (DEPTH / 2);
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic seq();
        seq_begin = 1; tick(); seq_begin = 0;
    endtask

    task automatic load(input logic [7:0] b);
        reg_wr_vld = 1; reg_wr_data = b; tick(); reg_wr_vld = 0;
    endtask

    task automatic commit(input bit is_reg, input logic [AW-1:0] a, input bit exp, input string tag);
        commit_req = 1; commit_is_reg = is_reg; commit_addr = a;
        tick();
        commit_req = 0;
        check({tag, " done"}, int'(commit_done), 1);
        check({tag, " ok"}, int'(commit_ok), int'(exp));
        if (wprot_n) check({tag, " R11 wel_clr"}, int'(wel_clr), int'(!exp));
    endtask

    task automatic rd(input logic [7:0] exp_d, input bit exp_ok, input string tag);
        reg_rd_req = 1; tick(); reg_rd_req = 0;
        check({tag, " rd_ok"}, int'(rd_ok), int'(exp_ok));
        check({tag, " rd_data"}, int'(rd_data), int'(exp_d));
    endtask

    task automatic write_reg(input logic [7:0] v, input bit exp, input string tag);
        seq(); load(v); commit(1'b1, '0, exp, tag);
        if (exp) mdl = v & 8'h8C;
        repeat (BURN + 1) tick();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int unused;
        unused = $urandom(32'h1F2E3D4C);
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        check("R1 done after reset", int'(commit_done), 0);
        seq(); rd(8'h00, 1, "R1 reset read");

        // R2 layout: all ones stores only 8C; R4 bp=11 does not block register
        write_reg(8'h0C, 1, "R4 set bp=11");
        write_reg(8'hFF, 1, "R4 reg commit under bp=11");
        seq(); rd(8'h8C, 1, "R2 stored mask");
        // R10 later reads invalid
        rd(8'h00, 0, "R10 second read");
        rd(8'h00, 0, "R10 third read");
        seq(); rd(8'h8C, 1, "R10 read after restart");

        // R5 lock active: pin low + bit7 -> register commit denied
        wprot_n = 0;
        seq(); load(8'h00); commit(1'b1, '0, 0, "R5 locked reg commit");
        check("R11 wel_clr pin low", int'(wel_clr), 1);
        repeat (BURN + 1) tick();
        seq(); rd(8'h8C, 1, "R5 register unchanged");
        // R6 array still decided by bp with pin low
        commit(1'b0, 11'h010, 0, "R6 bp=11 pin low");
        wprot_n = 1; tick();
        check("R11 wel_clr idle high pin", int'(wel_clr), 0);

        // R5 bit7 clear: pin low has no effect
        write_reg(8'h04, 1, "R5 set bp=01");
        wprot_n = 0;
        write_reg(8'h08, 1, "R5 pin low wpen=0 commit");
        wprot_n = 1;
        seq(); rd(8'h08, 1, "R5 value after unlocked commit");

        // R3 directed boundaries, bp=10
        commit(1'b0, 11'h3FF, 1, "R3 below half");
        commit(1'b0, 11'h400, 0, "R3 at half");
        write_reg(8'h04, 1, "R3 set bp=01");
        commit(1'b0, 11'h5FF, 1, "R3 below upper quarter");
        commit(1'b0, 11'h61F, 0, "R3 page base in quarter");
        write_reg(8'h00, 1, "R3 set bp=00");
        commit(1'b0, 11'h7FF, 1, "R3 none protected");

        // R7 overrun
        seq(); load(8'h04); load(8'h08); commit(1'b1, '0, 0, "R7 two bytes");
        repeat (BURN + 1) tick();
        seq(); rd(8'h00, 1, "R7 register kept");

        // R8 no staged byte
        seq(); commit(1'b1, '0, 0, "R8 nothing staged");

        // R9 and R13: visibility timing, commit during burn
        seq(); load(8'h88); commit(1'b1, '0, 1, "R9 commit");
        seq(); rd(8'h00, 1, "R9 old during burn");
        commit(1'b0, 11'h000, 0, "R13 commit during burn");
        repeat (BURN - 4) tick();
        seq(); rd(8'h88, 1, "R9 new after window");
        mdl = 8'h88;

        // R12 cancel by lock before burn
        seq(); load(8'h80);
        wprot_n = 0; tick(); wprot_n = 1;
        commit(1'b1, '0, 0, "R12 cancelled stage");
        repeat (BURN + 1) tick();
        seq(); rd(8'h88, 1, "R12 unchanged after cancel");
        // R12 pin low during burn does not stop update
        seq(); load(8'h84); commit(1'b1, '0, 1, "R12 commit before pin");
        wprot_n = 0; repeat (3) tick(); wprot_n = 1;
        repeat (BURN) tick();
        seq(); rd(8'h84, 1, "R12 update landed");
        mdl = 8'h84;

        // random array commits, R3 and R6
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            if (i % 50 == 0) write_reg(8'($urandom()), 1, "R2 random config");
            a = AW'($urandom());
            wprot_n = 1'($urandom());
            commit(1'b0, a, exp_array_ok(mdl, a), "R3 R6 random commit");
            if (!wprot_n) check("R11 random pin low", int'(wel_clr), 1);
            wprot_n = 1;
            if (i % 25 == 0) begin
                seq(); rd(mdl, 1, "R2 random readback");
            end
        end

        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule